// File: doc/BRIEF.md
# Multi-Device Reset Coordinator

This block controls the reset stage of a small system sequencer. The sequencer keeps its position in a 3-bit state register. While that register holds 000, this block is in charge. When the register enters 000, the block sends a single start strobe to each attached peripheral initialiser whose enable input is set. By default there are three such initialisers: converter A, converter B and a network controller. Initialisers that are not enabled get no strobe.

After the strobe, the block watches the done flag of each initialiser. Once every enabled initialiser reports done, the block raises a one-cycle advance pulse and presents the value 001 on its next-state output. The sequencer uses the pulse as the write enable of its state register. A device that is not enabled is treated as already finished. Done flags left high from an earlier visit cannot end the stage early, because completion is only accepted after the strobe of the current visit. The enables are expected to stay steady while the state is 000.

Top module: `mdev_reset_coord`

## Requirements
- R1: While reset is asserted (asynchronous, active-low), and after its release with the state input other than 000, every start line and the advance pulse are low and the next-state output is 000.
- R2: When the state input becomes 000, the start lines carry exactly one pulse, one cycle wide. It appears in the first cycle after the clock edge that samples 000. It is not repeated while the state stays at 000.
- R3: Start bit i pulses only if enable bit i is high. Bit 0 is converter A, bit 1 is converter B and bit 2 is the network controller. Enabled devices are strobed in the same cycle.
- R4: The advance pulse is never high while any enabled device has its done input low.
- R5: The advance pulse is one cycle wide. It is high in the first cycle, after the start cycle, in which the done inputs of all enabled devices are high. It follows the done inputs combinationally in that cycle.
- R6: The done input of a disabled device has no effect on the timing of the advance pulse, whether it is held high or low.
- R7: Done inputs that are already high before the start pulse do not count toward completion. The earliest possible advance pulse is in the cycle after the start cycle.
- R8: With every enable low, no start line pulses and the advance pulse comes in the second cycle after the edge that samples 000, which is the cycle right after the (silent) start cycle.
- R9: At most one advance pulse occurs per visit to state 000, even if the state stays at 000. A later re-entry starts a fresh cycle of strobe and wait.
- R10: If the state leaves 000 before completion, the visit is abandoned. Done inputs that rise afterwards produce no advance pulse.
- R11: The next-state output is 001 in every cycle in which the advance pulse is high, and 000 in all other cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| state_i | input | 3 | Current sequencer state |
| dev_en_i | input | 3 | Per-device enable (0 conv A, 1 conv B, 2 network) |
| dev_done_i | input | 3 | Per-device initialisation done flags |
| dev_start_o | output | 3 | Per-device one-cycle start strobe |
| adv_o | output | 1 | One-cycle completion pulse, state-register write enable |
| next_state_o | output | 3 | Value to load into the state register (001 during the pulse) |

## Verification
The embedded assertions check these rules on every cycle:
- a start strobe is never longer than one cycle;
- the advance pulse only appears in state 000;
- the advance pulse never occurs while an enabled device is still busy;
- the advance pulse never coincides with a strobe;
- the advance pulse never lasts two cycles.

Some behaviour is only visible through the directed scenarios, which check exact cycle positions. These cover the latency from state entry to the strobe and from the last done flag to the pulse. They also cover masking by the enables, immunity to stale done flags, the all-disabled shortcut, the single pulse per visit, and abandonment when the state is left early.

// File: rtl/mdrc_pkg.sv
`timescale 1ns/1ps
package mdrc_pkg;

   // Phase of the completion watcher within one visit to the active state.
   typedef enum logic {
      ARM_IDLE = 1'b0,
      ARM_WAIT = 1'b1
   } arm_e;

   // Device slot positions, used by integrators to wire the enable bus.
   localparam int unsigned SLOT_CONV_A = 0;
   localparam int unsigned SLOT_CONV_B = 1;
   localparam int unsigned SLOT_NET    = 2;

endpackage

// File: rtl/mdrc_rise.sv
`timescale 1ns/1ps
// Registered rising-edge detector: one-cycle pulse after level_i goes high.
module mdrc_rise (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic pulse_o
);

   logic level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0;
         pulse_o <= 1'b0;
      end else begin
         level_q <= level_i;
         pulse_o <= level_i & ~level_q;
      end
   end

   // R2
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);

endmodule

// File: rtl/mdrc_lane.sv
`timescale 1ns/1ps
// One device lane: gates the shared go pulse and reports whether the
// device no longer holds up completion.
module mdrc_lane (
   input  logic go_i,
   input  logic en_i,
   input  logic done_i,
   output logic start_o,
   output logic ok_o
);

   always_comb begin
      start_o = go_i & en_i;
      ok_o    = done_i | ~en_i;
   end

endmodule

// File: rtl/mdrc_arm.sv
`timescale 1ns/1ps
// Completion watcher: armed by the go pulse, fires once when all lanes
// report ok, dropped when the active state is left.
module mdrc_arm
   import mdrc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic go_i,
   input  logic all_ok_i,
   output logic fire_o
);

   arm_e phase_q, phase_d;

   always_comb begin
      phase_d = phase_q;
      fire_o  = 1'b0;
      unique case (phase_q)
         ARM_IDLE: begin
            if (go_i && active_i) phase_d = ARM_WAIT;
         end
         ARM_WAIT: begin
            if (!active_i) begin
               phase_d = ARM_IDLE;
            end else if (all_ok_i) begin
               fire_o  = 1'b1;
               phase_d = ARM_IDLE;
            end
         end
         default: phase_d = ARM_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= ARM_IDLE;
      else        phase_q <= phase_d;
   end

   // R9
   fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> !fire_o);

   // R7
   fire_after_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_i |-> !fire_o);

endmodule

// File: rtl/mdev_reset_coord.sv
`timescale 1ns/1ps
module mdev_reset_coord
   import mdrc_pkg::*;
#(
   parameter int unsigned      ST_W         = 3,
   parameter int unsigned      NUM_DEV      = 3,
   parameter logic [ST_W-1:0]  ACTIVE_STATE = '0,
   parameter logic [ST_W-1:0]  NEXT_STATE   = ST_W'(1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ST_W-1:0]    state_i,
   input  logic [NUM_DEV-1:0] dev_en_i,
   input  logic [NUM_DEV-1:0] dev_done_i,
   output logic [NUM_DEV-1:0] dev_start_o,
   output logic               adv_o,
   output logic [ST_W-1:0]    next_state_o
);

   localparam logic [NUM_DEV-1:0] ALL_OK = {NUM_DEV{1'b1}};

   // Elaboration-time parameter checks
   if (ST_W < 1) begin : g_bad_st_w
      $error("mdev_reset_coord: ST_W must be at least 1");
   end
   if (NUM_DEV < 1) begin : g_bad_num_dev
      $error("mdev_reset_coord: NUM_DEV must be at least 1");
   end
   if (NEXT_STATE == ACTIVE_STATE) begin : g_bad_next
      $error("mdev_reset_coord: NEXT_STATE must differ from ACTIVE_STATE");
   end

   logic               active;
   logic               go;
   logic [NUM_DEV-1:0] lane_ok;
   logic               all_ok;
   logic               fire;

   assign active = (state_i == ACTIVE_STATE);

   mdrc_rise u_rise (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (active),
      .pulse_o (go)
   );

   for (genvar g = 0; g < NUM_DEV; g++) begin : g_lane
      mdrc_lane u_lane (
         .go_i    (go),
         .en_i    (dev_en_i[g]),
         .done_i  (dev_done_i[g]),
         .start_o (dev_start_o[g]),
         .ok_o    (lane_ok[g])
      );
   end

   assign all_ok = (lane_ok == ALL_OK);

   mdrc_arm u_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (active),
      .go_i     (go),
      .all_ok_i (all_ok),
      .fire_o   (fire)
   );

   assign adv_o        = fire;
   assign next_state_o = fire ? NEXT_STATE : '0;

   // R2
   start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|dev_start_o) |=> (dev_start_o == '0));

   // R4
   adv_all_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv_o |-> ((dev_done_i | ~dev_en_i) == ALL_OK));

   // R10
   adv_in_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv_o |-> (state_i == ACTIVE_STATE));

   // R5
   adv_not_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv_o |-> (dev_start_o == '0));

endmodule

// File: tb/mdev_reset_coord_tb.sv
`timescale 1ns/1ps
module mdev_reset_coord_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [2:0] state;
   logic [2:0] en;
   logic [2:0] done;
   logic [2:0] start;
   logic       adv;
   logic [2:0] nxt;

   always #10 clk = ~clk;   // 50 MHz

   mdev_reset_coord u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .state_i      (state),
      .dev_en_i     (en),
      .dev_done_i   (done),
      .dev_start_o  (start),
      .adv_o        (adv),
      .next_state_o (nxt)
   );

   int n_run  = 0;
   int n_fail = 0;
   int cyc    = 0;

   // Device models: done falls on start, rises dly cycles later.
   int         dly [3];
   int         cnt [3];
   logic [2:0] start_seen = '0;
   logic       preset_req = 1'b0;
   logic [2:0] preset_val = '0;

   always @(posedge clk) cyc <= cyc + 1;

   initial begin
      done = '0;
      for (int i = 0; i < 3; i++) begin cnt[i] = 0; dly[i] = 1; end
   end

   always @(posedge clk) begin
      if (preset_req) begin
         done <= preset_val;
         for (int i = 0; i < 3; i++) cnt[i] <= 0;
      end else begin
         for (int i = 0; i < 3; i++) begin
            if (start_seen[i]) begin
               done[i] <= 1'b0;
               cnt[i]  <= dly[i];
            end else if (cnt[i] > 0) begin
               cnt[i] <= cnt[i] - 1;
               if (cnt[i] == 1) done[i] <= 1'b1;
            end
         end
      end
   end

   // Output monitor, sampled mid-cycle
   int         start_cnt, start_cyc, adv_cnt, adv_cyc, nxt_bad;
   logic [2:0] start_val;

   always @(negedge clk) begin
      start_seen = start;
      if (|start) begin
         start_cnt++;
         start_cyc = cyc;
         start_val = start;
      end
      if (adv) begin
         adv_cnt++;
         adv_cyc = cyc;
      end
      if (rst_n && (nxt !== (adv ? 3'b001 : 3'b000))) nxt_bad++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      start_cnt = 0; start_cyc = -1; adv_cnt = 0; adv_cyc = -1;
      nxt_bad = 0; start_val = '0;
   endtask

   task automatic preset(input logic [2:0] v);
      @(negedge clk);
      preset_val = v;
      preset_req = 1'b1;
      @(negedge clk);
      preset_req = 1'b0;
   endtask

   // One visit to state 000 with given enables and per-device delays.
   task automatic run_case(input string name, input logic [2:0] e,
                           input int d0, input int d1, input int d2,
                           input logic [2:0] pre, input int hold);
      int c0;
      int maxd;
      dly[0] = d0; dly[1] = d1; dly[2] = d2;
      @(negedge clk);
      en = e;
      preset(pre);
      @(negedge clk);
      clear_mon();
      maxd = 0;
      for (int i = 0; i < 3; i++) if (e[i] && dly[i] > maxd) maxd = dly[i];
      @(negedge clk);
      state = 3'b000;
      c0 = cyc;
      for (int k = 0; k < 40 && adv_cnt == 0; k++) @(negedge clk);
      @(negedge clk);
      if (e != 3'b000) begin
         // R2: single strobe right after the sampling edge
         chk(start_cyc == c0 + 1, {name, " R2 start cycle"}, start_cyc, c0 + 1);
         // R3: only enabled lanes strobed
         chk(start_val == e, {name, " R3 start mask"}, int'(start_val), int'(e));
      end
      // R2 / R8: strobe count (none when all disabled)
      chk(start_cnt == ((e != 3'b000) ? 1 : 0), {name, " R2 start count"},
          start_cnt, (e != 3'b000) ? 1 : 0);
      // R5 / R4 / R6 / R7 / R8: advance timing
      chk(adv_cyc == c0 + 2 + maxd, {name, " R5 advance cycle"}, adv_cyc, c0 + 2 + maxd);
      chk(adv_cnt == 1, {name, " R9 advance count"}, adv_cnt, 1);
      if (hold > 0) begin
         repeat (hold) @(negedge clk);
         // R9: staying in 000 does not repeat anything
         chk(adv_cnt == 1, {name, " R9 held advance count"}, adv_cnt, 1);
         chk(start_cnt == 1, {name, " R9 held start count"}, start_cnt, 1);
      end
      state = 3'b001;
      repeat (3) @(negedge clk);
      // R11: next-state value tracks the pulse
      chk(nxt_bad == 0, {name, " R11 next-state"}, nxt_bad, 0);
   endtask

   task automatic run_cancel();
      dly[0] = 6; dly[1] = 6; dly[2] = 6;
      @(negedge clk);
      en = 3'b111;
      preset(3'b000);
      @(negedge clk);
      clear_mon();
      @(negedge clk);
      state = 3'b000;
      repeat (4) @(negedge clk);
      state = 3'b011;
      repeat (12) @(negedge clk);
      // R10: no pulse after abandoning the visit
      chk(adv_cnt == 0, "cancel R10 advance count", adv_cnt, 0);
      chk(start_cnt == 1, "cancel R2 start count", start_cnt, 1);
      chk(nxt_bad == 0, "cancel R11 next-state", nxt_bad, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      state = 3'b010;
      en    = 3'b000;
      clear_mon();
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(start == 3'b000, "R1 start in reset", int'(start), 0);
      chk(adv == 1'b0, "R1 advance in reset", int'(adv), 0);
      chk(nxt == 3'b000, "R1 next-state in reset", int'(nxt), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(start_cnt == 0 && adv_cnt == 0, "R1 quiet after release",
          start_cnt + adv_cnt, 0);

      run_case("all_on",       3'b111, 3, 5, 2, 3'b000, 0);   // R3 R5
      run_case("a_net_only",   3'b101, 4, 9, 7, 3'b000, 0);   // R6 low
      run_case("b_only_stale", 3'b010, 1, 6, 1, 3'b111, 0);   // R6 high, R7
      run_case("none",         3'b000, 1, 1, 1, 3'b000, 0);   // R8
      run_case("stale_all",    3'b111, 1, 1, 1, 3'b111, 0);   // R7
      run_case("hold_visit",   3'b011, 2, 3, 1, 3'b000, 10);  // R9
      run_cancel();                                            // R10
      run_case("reenter",      3'b100, 1, 1, 4, 3'b000, 0);   // R9 rearm

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule